// File: doc/BRIEF.md
# Multi-View General Register File

This block holds sixteen 16-bit general registers. One write port and one read port each take a view selector and a register index. The same storage can be reached as 8-bit halves, single words, 32-bit pairs, 64-bit quads, or a segmented pointer. The segmented pointer is a 7-bit segment number plus a 16-bit offset, kept in a register pair. The block sits beside a datapath that issues one register read and one register write per cycle, with operands of different sizes.

The read port is a pure combinational view of the stored words. A write lands on the rising clock edge. Pair, quad and pointer views must use an aligned index. A misaligned index, or a view code outside the defined set, raises the error output of that port. When this happens, nothing is stored and the read data is zero.

View codes on `wr_view` and `rd_view`: 0 byte, 1 word, 2 pair, 3 quad, 4 segmented pointer, 5 to 7 undefined. Data is right-aligned in the 64-bit data buses and zero-extended on reads.

Top module: `regfile_multiview`

## Requirements
- R1: Byte view (code 0) uses index bits 2:0 to pick one of words 0 to 7. Index bit 3 clear addresses bits 15:8 of that word, and set addresses bits 7:0. The byte travels in data bits 7:0, and reads return it zero-extended.
- R2: A byte write stores only the addressed half. The other half of the word keeps its value.
- R3: Word view (code 1) writes data bits 15:0 into word n and reads word n back in bits 15:0.
- R4: Pair view (code 2) at index n maps data bits 31:16 to word n and bits 15:0 to word n+1, for both write and read.
- R5: Quad view (code 3) at index n maps data bits 63:48, 47:32, 31:16 and 15:0 to words n, n+1, n+2 and n+3 in that order.
- R6: Pointer view (code 4) write puts data bits 22:16 (the segment) into bits 14:8 of word n and clears every other bit of word n. It stores data bits 15:0 (the offset) in word n+1. A pointer read returns the segment in bits 22:16 and the offset in bits 15:0.
- R7: The port's error output is high, the write changes no word, and a read returns zero in any of these cases:
  - a pair or pointer access has an odd index;
  - a quad access has an index that is not a multiple of 4;
  - the view code is 5 to 7.
- R8: Read data follows the current stored words within the same cycle. A write becomes visible only after the rising clock edge on which it is presented.
- R9: A synchronous reset, active high, clears all sixteen words to zero on the next rising edge.
- R10: With the write enable low, no word changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_view | input | 3 | Write view code |
| wr_idx | input | 4 | Write register index |
| wr_data | input | 64 | Write data, right-aligned |
| wr_err | output | 1 | Write rejected (misaligned or undefined view) |
| rd_view | input | 3 | Read view code |
| rd_idx | input | 4 | Read register index |
| rd_data | output | 64 | Read data, zero-extended |
| rd_err | output | 1 | Read rejected (misaligned or undefined view) |

## Verification
The error outputs and the read data are combinational, so they are due in the same cycle as the inputs that select them. The bench samples them 1 ns after it drives those inputs, with no clock edge in between. A write is due one edge after it is presented. The bench drives it at a falling edge, reads the old value before the next rising edge, and reads the new value 1 ns after that edge. Reset takes effect on the first rising edge with reset high, and all sixteen words are read back through the word view.

// File: rtl/rfmv_pkg.sv
package rfmv_pkg;

   typedef enum logic [2:0] {
      VW_BYTE = 3'd0,
      VW_WORD = 3'd1,
      VW_PAIR = 3'd2,
      VW_QUAD = 3'd3,
      VW_SPTR = 3'd4
   } view_e;

   // True when the view/index combination may not be carried out.
   function automatic logic view_reject(input logic [2:0] view, input logic [1:0] idx_lo);
      logic bad;
      case (view)
         3'd0, 3'd1: bad = 1'b0;
         3'd2, 3'd4: bad = idx_lo[0];
         3'd3:       bad = |idx_lo;
         default:    bad = 1'b1;
      endcase
      return bad;
   endfunction

endpackage

// File: rtl/rfmv_wr_decode.sv
module rfmv_wr_decode
   import rfmv_pkg::*;
#(
   parameter int NUM_WORDS = 16,
   parameter int WORD_W    = 16,
   parameter int SEG_W     = 7,
   parameter int IDX_W     = $clog2(NUM_WORDS),
   parameter int DATA_W    = 4 * WORD_W
) (
   input  logic                              en_i,
   input  logic [2:0]                        view_i,
   input  logic [IDX_W-1:0]                  idx_i,
   input  logic [DATA_W-1:0]                 data_i,
   input  logic [NUM_WORDS-1:0][WORD_W-1:0]  words_i,
   output logic [NUM_WORDS-1:0]              we_o,
   output logic [NUM_WORDS-1:0][WORD_W-1:0]  wd_o,
   output logic                              err_o
);
   localparam int HW   = WORD_W / 2;
   localparam int HALF = NUM_WORDS / 2;

   logic reject;
   assign reject = view_reject(view_i, idx_i[1:0]);
   assign err_o  = en_i & reject;

   for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
      localparam bit BYTE_OK = (i < HALF);
      int off;
      always_comb begin
         off      = i - int'(idx_i);
         we_o[i]  = 1'b0;
         wd_o[i]  = words_i[i];
         if (en_i && !reject) begin
            case (view_i)
               3'd0: begin
                  if (BYTE_OK && (int'(idx_i[IDX_W-2:0]) == i)) begin
                     we_o[i] = 1'b1;
                     if (idx_i[IDX_W-1]) wd_o[i][HW-1:0]      = data_i[HW-1:0];
                     else                wd_o[i][WORD_W-1:HW] = data_i[HW-1:0];
                  end
               end
               3'd1: begin
                  if (off == 0) begin
                     we_o[i] = 1'b1;
                     wd_o[i] = data_i[WORD_W-1:0];
                  end
               end
               3'd2: begin
                  if (off == 0 || off == 1) begin
                     we_o[i] = 1'b1;
                     wd_o[i] = data_i[(1-off)*WORD_W +: WORD_W];
                  end
               end
               3'd3: begin
                  if (off >= 0 && off <= 3) begin
                     we_o[i] = 1'b1;
                     wd_o[i] = data_i[(3-off)*WORD_W +: WORD_W];
                  end
               end
               3'd4: begin
                  if (off == 0) begin
                     we_o[i] = 1'b1;
                     wd_o[i] = '0;
                     wd_o[i][HW +: SEG_W] = data_i[WORD_W +: SEG_W];
                  end else if (off == 1) begin
                     we_o[i] = 1'b1;
                     wd_o[i] = data_i[WORD_W-1:0];
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/rfmv_rd_mux.sv
module rfmv_rd_mux
   import rfmv_pkg::*;
#(
   parameter int NUM_WORDS = 16,
   parameter int WORD_W    = 16,
   parameter int SEG_W     = 7,
   parameter int IDX_W     = $clog2(NUM_WORDS),
   parameter int DATA_W    = 4 * WORD_W
) (
   input  logic [2:0]                        view_i,
   input  logic [IDX_W-1:0]                  idx_i,
   input  logic [NUM_WORDS-1:0][WORD_W-1:0]  words_i,
   output logic [DATA_W-1:0]                 data_o,
   output logic                              err_o
);
   localparam int HW = WORD_W / 2;

   logic [IDX_W-1:0]  i1, i2, i3;
   logic [WORD_W-1:0] w0, w1, w2, w3, wb;

   assign i1 = idx_i + IDX_W'(1);
   assign i2 = idx_i + IDX_W'(2);
   assign i3 = idx_i + IDX_W'(3);
   assign w0 = words_i[idx_i];
   assign w1 = words_i[i1];
   assign w2 = words_i[i2];
   assign w3 = words_i[i3];
   assign wb = words_i[{1'b0, idx_i[IDX_W-2:0]}];

   assign err_o = view_reject(view_i, idx_i[1:0]);

   always_comb begin
      data_o = '0;
      if (!err_o) begin
         case (view_i)
            3'd0: data_o[HW-1:0] = idx_i[IDX_W-1] ? wb[HW-1:0] : wb[WORD_W-1:HW];
            3'd1: data_o[WORD_W-1:0] = w0;
            3'd2: data_o[2*WORD_W-1:0] = {w0, w1};
            3'd3: data_o = {w0, w1, w2, w3};
            3'd4: data_o[WORD_W+SEG_W-1:0] = {w0[HW +: SEG_W], w1};
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/regfile_multiview.sv
module regfile_multiview
   import rfmv_pkg::*;
#(
   parameter int NUM_WORDS = 16,
   parameter int WORD_W    = 16,
   parameter int SEG_W     = 7,
   localparam int IDX_W    = $clog2(NUM_WORDS),
   localparam int DATA_W   = 4 * WORD_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [2:0]        wr_view,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_err,
   input  logic [2:0]        rd_view,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_err
);
   if (NUM_WORDS < 4 || (NUM_WORDS % 4) != 0 || (1 << IDX_W) != NUM_WORDS) begin : g_bad_depth
      $error("NUM_WORDS must be a power of two and at least 4");
   end
   if (WORD_W < 2 || (WORD_W % 2) != 0) begin : g_bad_width
      $error("WORD_W must be even");
   end
   if (SEG_W < 1 || SEG_W > WORD_W / 2) begin : g_bad_seg
      $error("SEG_W must fit in the upper half of a word");
   end

   logic [NUM_WORDS-1:0][WORD_W-1:0] regs_q;
   logic [NUM_WORDS-1:0][WORD_W-1:0] wd;
   logic [NUM_WORDS-1:0]             we;

   rfmv_wr_decode #(
      .NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .SEG_W(SEG_W),
      .IDX_W(IDX_W), .DATA_W(DATA_W)
   ) u_wdec (
      .en_i(wr_en), .view_i(wr_view), .idx_i(wr_idx), .data_i(wr_data),
      .words_i(regs_q), .we_o(we), .wd_o(wd), .err_o(wr_err)
   );

   for (genvar i = 0; i < NUM_WORDS; i++) begin : g_store
      always_ff @(posedge clk) begin
         if (rst)        regs_q[i] <= '0;
         else if (we[i]) regs_q[i] <= wd[i];
      end
   end

   rfmv_rd_mux #(
      .NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .SEG_W(SEG_W),
      .IDX_W(IDX_W), .DATA_W(DATA_W)
   ) u_rmux (
      .view_i(rd_view), .idx_i(rd_idx), .words_i(regs_q),
      .data_o(rd_data), .err_o(rd_err)
   );

   // R9: reset empties every word on the following edge
   a_r9_reset_clears: assert property (@(posedge clk) rst |=> (regs_q == '0));
   // R7: a rejected write leaves the storage untouched
   a_r7_reject_holds: assert property (@(posedge clk) disable iff (rst)
      wr_err |=> $stable(regs_q));
   // R10: no enable, no change
   a_r10_idle_holds: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> $stable(regs_q));
   // R1: a byte write touches exactly one word
   a_r1_byte_one_word: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_view == 3'd0) |-> ($countones(we) == 1));
   // R4: a pair write touches two words
   a_r4_pair_two_words: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_view == 3'd2 && !wr_err) |-> ($countones(we) == 2));
   // R5: a quad write touches four words
   a_r5_quad_four_words: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_view == 3'd3 && !wr_err) |-> ($countones(we) == 4));
   // R7: a rejected read returns zero
   a_r7_read_reject_zero: assert property (@(posedge clk) disable iff (rst)
      rd_err |-> (rd_data == '0));

endmodule

// File: tb/sim_regfile_multiview.sv
`timescale 1ns/1ps
module sim_regfile_multiview;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_view = 3'd0;
   logic [3:0]  wr_idx = 4'd0;
   logic [63:0] wr_data = '0;
   logic        wr_err;
   logic [2:0]  rd_view = 3'd1;
   logic [3:0]  rd_idx = 4'd0;
   logic [63:0] rd_data;
   logic        rd_err;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   regfile_multiview u0 (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_view(wr_view), .wr_idx(wr_idx),
      .wr_data(wr_data), .wr_err(wr_err), .rd_view(rd_view), .rd_idx(rd_idx),
      .rd_data(rd_data), .rd_err(rd_err)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [2:0] v, input logic [3:0] i, output logic [63:0] d);
      rd_view = v; rd_idx = i; #1; d = rd_data;
   endtask

   task automatic wr(input logic [2:0] v, input logic [3:0] i, input logic [63:0] d);
      @(negedge clk);
      wr_view = v; wr_idx = i; wr_data = d; wr_en = 1'b1;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic t_reset;
      logic [63:0] d;
      for (int k = 0; k < 16; k++) begin
         rd(3'd1, 4'(k), d);
         chk("R9 reset word", d, 64'h0);
      end
   endtask

   task automatic t_word_timing;
      logic [63:0] d;
      wr(3'd1, 4'd3, 64'h0000_0000_0000_BEEF);
      rd(3'd1, 4'd3, d); chk("R3 word", d, 64'hBEEF);
      @(negedge clk);
      wr_view = 3'd1; wr_idx = 4'd3; wr_data = 64'h1357; wr_en = 1'b1;
      rd(3'd1, 4'd3, d); chk("R8 old before edge", d, 64'hBEEF);
      @(posedge clk); #1; wr_en = 1'b0;
      rd(3'd1, 4'd3, d); chk("R8 new after edge", d, 64'h1357);
   endtask

   task automatic t_byte;
      logic [63:0] d;
      wr(3'd1, 4'd2, 64'h1234);
      wr(3'd0, 4'd2, 64'hFFFF_FFAB);
      rd(3'd1, 4'd2, d); chk("R2 high byte keeps low", d, 64'hAB34);
      wr(3'd0, 4'd10, 64'h00CD);
      rd(3'd1, 4'd2, d); chk("R2 low byte keeps high", d, 64'hABCD);
      rd(3'd0, 4'd10, d); chk("R1 read low byte", d, 64'hCD);
      rd(3'd0, 4'd2, d); chk("R1 read high byte", d, 64'hAB);
      wr(3'd0, 4'd15, 64'h5A);
      rd(3'd1, 4'd7, d); chk("R1 byte idx 15 -> word 7 low", d, 64'h005A);
   endtask

   task automatic t_pair;
      logic [63:0] d;
      wr(3'd2, 4'd4, 64'hFFFF_FFFF_DEAD_C0DE);
      rd(3'd1, 4'd4, d); chk("R4 pair upper in n", d, 64'hDEAD);
      rd(3'd1, 4'd5, d); chk("R4 pair lower in n+1", d, 64'hC0DE);
      rd(3'd2, 4'd4, d); chk("R4 pair read", d, 64'hDEAD_C0DE);
   endtask

   task automatic t_quad;
      logic [63:0] d;
      wr(3'd3, 4'd8, 64'h1111_2222_3333_4444);
      rd(3'd1, 4'd8, d);  chk("R5 quad word n",   d, 64'h1111);
      rd(3'd1, 4'd11, d); chk("R5 quad word n+3", d, 64'h4444);
      rd(3'd3, 4'd8, d);  chk("R5 quad read", d, 64'h1111_2222_3333_4444);
   endtask

   task automatic t_sptr;
      logic [63:0] d;
      wr(3'd1, 4'd12, 64'hFFFF);
      wr(3'd4, 4'd12, 64'hFFFF_FFFF_FFA5_6789);
      rd(3'd1, 4'd12, d); chk("R6 segment word", d, 64'h2500);
      rd(3'd1, 4'd13, d); chk("R6 offset word", d, 64'h6789);
      rd(3'd4, 4'd12, d); chk("R6 pointer read", d, 64'h25_6789);
   endtask

   task automatic t_reject;
      logic [63:0] d;
      @(negedge clk);
      wr_view = 3'd2; wr_idx = 4'd5; wr_data = 64'h9999_9999; wr_en = 1'b1;
      #1; chk("R7 odd pair err", {63'b0, wr_err}, 64'h1);
      @(posedge clk); #1; wr_en = 1'b0;
      rd(3'd1, 4'd5, d); chk("R7 odd pair no write", d, 64'hC0DE);
      wr(3'd3, 4'd6, 64'h7777_7777_7777_7777);
      rd(3'd1, 4'd7, d); chk("R7 quad misaligned no write", d, 64'h005A);
      wr(3'd4, 4'd3, 64'h7F_0000);
      rd(3'd1, 4'd4, d); chk("R7 odd pointer no write", d, 64'hDEAD);
      wr(3'd6, 4'd4, 64'h1);
      rd(3'd1, 4'd4, d); chk("R7 bad view no write", d, 64'hDEAD);
      rd(3'd2, 4'd3, d); chk("R7 read reject data", d, 64'h0);
      chk("R7 read reject flag", {63'b0, rd_err}, 64'h1);
      rd(3'd3, 4'd8, d); chk("R7 aligned quad no flag", {63'b0, rd_err}, 64'h0);
   endtask

   task automatic t_idle;
      logic [63:0] d;
      @(negedge clk);
      wr_view = 3'd1; wr_idx = 4'd3; wr_data = 64'hFFFF; wr_en = 1'b0;
      @(posedge clk); #1;
      rd(3'd1, 4'd3, d); chk("R10 disabled write", d, 64'h1357);
   endtask

   task automatic t_rereset;
      logic [63:0] d;
      @(negedge clk); rst = 1'b1;
      @(posedge clk); #1;
      rd(3'd3, 4'd8, d); chk("R9 reset mid-run", d, 64'h0);
      @(negedge clk); rst = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 1'b0;
      t_reset();
      t_word_timing();
      t_byte();
      t_pair();
      t_quad();
      t_sptr();
      t_reject();
      t_idle();
      t_rereset();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule